// File: doc/BRIEF.md
# Bank-Threshold Chip-Select Decoder

This block turns a 21-bit program fetch address into three active-low chip-select strobes. Two strobes enable program memory and one enables an I/O expansion device. The address space is treated as 256 banks of 8 KB, and the bank number is the top eight address bits. Two software-written 8-bit bank thresholds place the region boundaries. Each boundary is found by a greater-or-equal comparison, not by an exact match, so a single register value splits the space into a part below the boundary and a part at or above it.

The I/O region has the highest priority, then the upper memory region, then the lower memory region. The lower region holds every bank below the upper-memory threshold. If that threshold is zero, the lower region holds every bank below the I/O threshold instead. A threshold of zero switches its own strobe off. When both thresholds are zero, decoding stops and a flag tells the pad logic to use the pins as general I/O. The top 512 bytes of the space belong to internal RAM and never raise a strobe. A strobe can assert only while the fetch-valid input is high.

The decision is held in a small state register, `sel_q`. It has four states: `SEL_NONE` (all strobes high), `SEL_MEM_LO`, `SEL_MEM_HI` and `SEL_IO`. On every clock the state moves to whichever state the current inputs select. Every state can go to every other state in one step. The named transitions are enter-region (from `SEL_NONE` into a region), cross-boundary (from one region to another) and release (from a region back to `SEL_NONE`, caused by an invalid fetch, a RAM address, a disabled region or reset). Reset forces `SEL_NONE`.

Top module: `bank_cs_decoder`

## Requirements
- R1: After reset both thresholds read back as FFh. Select 0 of the register port is the upper-memory threshold and select 1 is the I/O threshold.
- R2: A register write takes effect at the clock edge where the write enable is high. `cfg_rdata` shows the register chosen by `cfg_sel` one clock after `cfg_sel` is presented.
- R3: With a non-zero I/O threshold T, `io_cs_n` is low for a valid fetch whose bank (address bits [20:13]) is at least T. It is high otherwise.
- R4: With a non-zero upper threshold H, `mem_hi_cs_n` is low for a valid fetch with bank ≥ H, unless the I/O select claims that fetch. It is high for banks below H.
- R5: `mem_lo_cs_n` is low for a valid fetch with bank below H when H is non-zero. When H is zero it is low for banks below the I/O threshold. In both cases it stays high when a higher-priority select claims the fetch.
- R6: A threshold of 00h keeps its own strobe high for every address.
- R7: When both thresholds are 00h, all strobes stay high and `pins_gpio` is 1. Otherwise `pins_gpio` is 0.
- R8: A fetch to 1FFE00h–1FFFFFh asserts no strobe.
- R9: While `fetch_valid` is low, all strobes are high.
- R10: At most one strobe is low at any time.
- R11: The strobes are registered. They reflect the address and valid presented before a clock edge only after that edge, and they do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Threshold write enable |
| cfg_sel | input | 1 | Register select: 0 for the upper-memory threshold, 1 for the I/O threshold |
| cfg_wdata | input | 8 | Threshold write data |
| cfg_rdata | output | 8 | Registered read-back of the selected threshold |
| fetch_addr | input | 21 | Program fetch address |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| mem_lo_cs_n | output | 1 | Lower program-memory select, active low |
| mem_hi_cs_n | output | 1 | Upper program-memory select, active low |
| io_cs_n | output | 1 | I/O expansion select, active low |
| pins_gpio | output | 1 | Both thresholds are zero, so the pins act as general I/O |

## Verification
Each strobe is due one clock after its address and valid are presented. The bench drives on the falling edge and compares just after the next rising edge. One check samples before that edge and confirms the old strobe value is still present. Read-back data is due one edge after `cfg_sel` changes and is sampled the same way. A threshold write moves `pins_gpio` right after its write edge, but it changes the strobes only one edge later. For that reason, every sweep begins with a settling fetch.

// File: rtl/csd_pkg.sv
package csd_pkg;

    // Each state value is the active-low strobe vector {io, hi, lo},
    // so the outputs are direct flop bits.
    typedef enum logic [2:0] {
        SEL_NONE   = 3'b111,
        SEL_MEM_LO = 3'b110,
        SEL_MEM_HI = 3'b101,
        SEL_IO     = 3'b011
    } sel_e;

    localparam logic CFG_SEL_HI = 1'b0;
    localparam logic CFG_SEL_IO = 1'b1;

endpackage

// File: rtl/csd_thresh_regs.sv
module csd_thresh_regs
    import csd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] th_hi,
    output logic [DATA_W-1:0] th_io
);

    localparam logic [DATA_W-1:0] RESET_VAL = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            th_hi <= RESET_VAL;
            th_io <= RESET_VAL;
        end else if (we) begin
            if (sel == CFG_SEL_IO) th_io <= wdata;
            else                   th_hi <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata <= RESET_VAL;
        else        rdata <= (sel == CFG_SEL_IO) ? th_io : th_hi;
    end

    // After a write edge, the written register holds the written data.
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we) |-> (($past(sel) == CFG_SEL_IO) ? th_io : th_hi) == $past(wdata)); // R2

endmodule

// File: rtl/csd_region_cmp.sv
module csd_region_cmp
    import csd_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int BANK_W = 8,
    parameter int RAM_W  = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              valid,
    input  logic [BANK_W-1:0] th_hi,
    input  logic [BANK_W-1:0] th_io,
    output sel_e              next_sel,
    output logic              pins_gpio
);

    localparam int RAM_TAG_W = ADDR_W - RAM_W;

    logic [BANK_W-1:0]    bank;
    logic [RAM_TAG_W-1:0] ram_tag;
    logic                 in_ram;
    logic                 hi_on, io_on;
    logic                 io_hit, hi_hit, lo_hit;
    logic [BANK_W-1:0]    lo_limit;

    always_comb begin
        bank     = addr[ADDR_W-1 -: BANK_W];
        ram_tag  = addr[ADDR_W-1 -: RAM_TAG_W];
        in_ram   = &ram_tag;
        hi_on    = |th_hi;
        io_on    = |th_io;
        io_hit   = io_on && (bank >= th_io);
        hi_hit   = hi_on && (bank >= th_hi);
        lo_limit = hi_on ? th_hi : th_io;
        lo_hit   = (hi_on || io_on) && (bank < lo_limit);
        pins_gpio = !hi_on && !io_on;
    end

    always_comb begin
        if (!valid || in_ram) next_sel = SEL_NONE;
        else if (io_hit)      next_sel = SEL_IO;
        else if (hi_hit)      next_sel = SEL_MEM_HI;
        else if (lo_hit)      next_sel = SEL_MEM_LO;
        else                  next_sel = SEL_NONE;
    end

endmodule

// File: rtl/csd_select_fsm.sv
module csd_select_fsm
    import csd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  sel_e next_sel,
    output logic cs_lo_n,
    output logic cs_hi_n,
    output logic cs_io_n
);

    sel_e sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= SEL_NONE;
        else        sel_q <= next_sel;
    end

    always_comb begin
        unique case (sel_q)
            SEL_NONE:   {cs_io_n, cs_hi_n, cs_lo_n} = 3'b111;
            SEL_MEM_LO: {cs_io_n, cs_hi_n, cs_lo_n} = 3'b110;
            SEL_MEM_HI: {cs_io_n, cs_hi_n, cs_lo_n} = 3'b101;
            SEL_IO:     {cs_io_n, cs_hi_n, cs_lo_n} = 3'b011;
            default:    {cs_io_n, cs_hi_n, cs_lo_n} = 3'b111;
        endcase
    end

    // The state follows the decision made one edge earlier.
    AST_STATE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q == $past(next_sel)); // R11

endmodule

// File: rtl/bank_cs_decoder.sv
module bank_cs_decoder
    import csd_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int BANK_W = 8,
    parameter int RAM_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [BANK_W-1:0] cfg_wdata,
    output logic [BANK_W-1:0] cfg_rdata,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_valid,
    output logic              mem_lo_cs_n,
    output logic              mem_hi_cs_n,
    output logic              io_cs_n,
    output logic              pins_gpio
);

    localparam int RAM_TAG_W = ADDR_W - RAM_W;

    logic [BANK_W-1:0] th_hi, th_io;
    sel_e              next_sel;

    csd_thresh_regs #(.DATA_W(BANK_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .th_hi (th_hi),
        .th_io (th_io)
    );

    csd_region_cmp #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .RAM_W(RAM_W)) u_cmp (
        .addr      (fetch_addr),
        .valid     (fetch_valid),
        .th_hi     (th_hi),
        .th_io     (th_io),
        .next_sel  (next_sel),
        .pins_gpio (pins_gpio)
    );

    csd_select_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .next_sel(next_sel),
        .cs_lo_n (mem_lo_cs_n),
        .cs_hi_n (mem_hi_cs_n),
        .cs_io_n (io_cs_n)
    );

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({io_cs_n, mem_hi_cs_n, mem_lo_cs_n}) >= 2); // R10

    AST_IDLE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fetch_valid) |-> (io_cs_n && mem_hi_cs_n && mem_lo_cs_n)); // R9

    AST_RAM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&$past(fetch_addr[ADDR_W-1 -: RAM_TAG_W])) |-> (io_cs_n && mem_hi_cs_n && mem_lo_cs_n)); // R8

    AST_GPIO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pins_gpio) |-> (io_cs_n && mem_hi_cs_n && mem_lo_cs_n)); // R7

    AST_IO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(th_io) == '0) |-> io_cs_n); // R6

    AST_HI_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fetch_addr[ADDR_W-1 -: BANK_W]) < $past(th_hi)) |-> mem_hi_cs_n); // R4

endmodule

// File: tb/bank_cs_decoder_bench.sv
module bank_cs_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [20:0] fetch_addr = '0;
    logic        fetch_valid = 1'b0;
    logic        mem_lo_cs_n, mem_hi_cs_n, io_cs_n, pins_gpio;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_hi = 8'hFF;
    logic [7:0] m_io = 8'hFF;

    always #5 clk = ~clk;

    bank_cs_decoder u_bank_cs_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
        .mem_lo_cs_n(mem_lo_cs_n), .mem_hi_cs_n(mem_hi_cs_n),
        .io_cs_n(io_cs_n), .pins_gpio(pins_gpio)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected strobes {io, hi, lo}, active low, from the stated rules.
    function automatic logic [2:0] model(input logic [20:0] a, input logic v,
                                         input logic [7:0] h, input logic [7:0] t);
        int bank;
        int top;
        bank = int'(a) / 8192;
        if (!v || int'(a) >= 2097152 - 512) return 3'b111;
        if (t != 0 && bank >= int'(t)) return 3'b011;
        if (h != 0 && bank >= int'(h)) return 3'b101;
        top = (h != 0) ? int'(h) : int'(t);
        if (top != 0 && bank < top) return 3'b110;
        return 3'b111;
    endfunction

    function automatic string tag(input logic [2:0] e, input logic [7:0] h, input logic [7:0] t);
        if (e == 3'b011) return "R3";
        if (e == 3'b101) return "R4";
        if (e == 3'b110) return "R5";
        if (h == 0 && t == 0) return "R7";
        return "R6";
    endfunction

    task automatic wr(input logic s, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (s) m_io = d; else m_hi = d;
    endtask

    task automatic rd(input logic s, input logic [7:0] exp, input string req);
        @(negedge clk);
        cfg_sel = s;
        @(posedge clk); #1;
        check(req, cfg_rdata, exp);
    endtask

    task automatic fetch(input logic [20:0] a, input logic v, input string req);
        logic [2:0] e;
        @(negedge clk);
        fetch_addr = a; fetch_valid = v;
        @(posedge clk); #1;
        e = model(a, v, m_hi, m_io);
        check((req == "") ? tag(e, m_hi, m_io) : req,
              {5'b0, io_cs_n, mem_hi_cs_n, mem_lo_cs_n}, {5'b0, e});
        if (!io_cs_n + !mem_hi_cs_n + !mem_lo_cs_n > 1)
            check("R10", 8'd1, 8'd0);
    endtask

    task automatic sweep(input logic [7:0] h, input logic [7:0] t);
        wr(1'b0, h);
        wr(1'b1, t);
        fetch(21'h0, 1'b0, "R9");
        check("R7", {7'b0, pins_gpio}, {7'b0, (h == 0 && t == 0)});
        for (int b = 0; b < 256; b++)
            fetch(21'(b * 8192 + ((b * 37) % 4096)), 1'b1, "");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9", {5'b0, io_cs_n, mem_hi_cs_n, mem_lo_cs_n}, 8'h07);
        @(negedge clk); rst_n = 1'b1;
        rd(1'b0, 8'hFF, "R1");
        rd(1'b1, 8'hFF, "R1");
        check("R7", {7'b0, pins_gpio}, 8'h00);

        // Reset thresholds: only bank FF reaches the I/O select.
        for (int b = 0; b < 256; b++)
            fetch(21'(b * 8192 + 21'h123), 1'b1, "");

        // Read latency: rdata changes only after the edge that samples sel.
        wr(1'b0, 8'h5A);
        wr(1'b1, 8'hA5);
        rd(1'b0, 8'h5A, "R2");
        @(negedge clk); cfg_sel = 1'b1; #1;
        check("R2", cfg_rdata, 8'h5A);
        @(posedge clk); #1;
        check("R2", cfg_rdata, 8'hA5);

        // Registered strobes: no change before the edge.
        fetch(21'h00_0000, 1'b1, "R5");
        @(negedge clk); fetch_addr = 21'h1F_0000; #1;
        check("R11", {5'b0, io_cs_n, mem_hi_cs_n, mem_lo_cs_n}, 8'h06);
        @(posedge clk); #1;
        check("R11", {5'b0, io_cs_n, mem_hi_cs_n, mem_lo_cs_n}, 8'h03);

        sweep(8'h40, 8'hC0);
        sweep(8'hC0, 8'h40);
        sweep(8'h00, 8'h80);
        sweep(8'h80, 8'h00);
        sweep(8'h01, 8'h01);
        sweep(8'hFF, 8'hFF);

        // RAM window edges with I/O enabled at bank FF.
        fetch(21'h1FFDFF, 1'b1, "R3");
        fetch(21'h1FFE00, 1'b1, "R8");
        fetch(21'h1FFFFF, 1'b1, "R8");
        fetch(21'h1FFE00, 1'b0, "R9");
        fetch(21'h1F0000, 1'b0, "R9");

        sweep(8'h00, 8'h00);
        fetch(21'h1FFDFF, 1'b1, "R7");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule